// File: doc/BRIEF.md
# Configurable Wake Output Driver

This block drives a remote-wake pad from an internal wake request. Three configuration bits arrive at start-up together with a valid strobe. One bit sets which pin level means "wake". One bit lets a low power-good input float the pin. The third bit picks a push-pull driver or an open-drain driver. The block outputs a pad data value and a pad output-enable, so the pad logic can build either a tri-state buffer or an open-drain buffer from them.

From power-on reset until the first valid strobe, the pin floats, because the polarity and the drive type are not yet known. The configuration is latched once and then holds until the next power-on reset. A separate registered indicator follows the magic-packet wake mode. It can drive an LED or logic that moves the device onto auxiliary power.

Top module: `wake_pin_driver`

## Requirements
- R1: While `rst_n` is low, `pin_oe` is 0, `pin_o` is 0 and `mode_led` is 0.
- R2: After reset and before the first `cfg_valid` pulse, `pin_oe` stays 0 whatever `wake_req` and `pwr_good` are.
- R3: The configuration bits are captured on the first rising clock edge with `cfg_valid` high. Later `cfg_valid` pulses have no effect until the next reset, and a new reset allows a new capture.
- R4: In push-pull mode (`cfg_odrain`=0), with the pin not gated off, `pin_oe` is 1. `pin_o` equals `cfg_pol` when `wake_req` is 1 and equals the inverse of `cfg_pol` when `wake_req` is 0. So `cfg_pol`=1 means that wake is shown as a high level.
- R5: In open-drain mode (`cfg_odrain`=1), with the pin not gated off, `pin_oe` is 1 exactly when the wanted level is low, and `pin_o` is 0. The wanted level is the same as in R4.
- R6: When the captured gate bit is 1 and `pwr_good` is 0, `pin_oe` is 0 whatever `wake_req` is. When the gate bit is 0, `pwr_good` has no effect.
- R7: `mode_led` takes the value of `magic_mode` at each rising clock edge. A change on `magic_mode` does not show before that edge.
- R8: `pin_o` is 0 whenever `pin_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cfg_valid | input | 1 | Strobe that marks the configuration bits as valid |
| cfg_pol | input | 1 | 1: wake drives the pin high; 0: wake drives the pin low |
| cfg_gate | input | 1 | 1: a low `pwr_good` floats the pin |
| cfg_odrain | input | 1 | 1: open-drain; 0: push-pull |
| wake_req | input | 1 | Internal wake request |
| pwr_good | input | 1 | Main power good |
| magic_mode | input | 1 | Magic-packet wake mode active |
| pin_o | output | 1 | Pad data value |
| pin_oe | output | 1 | Pad output-enable |
| mode_led | output | 1 | Registered wake-mode indicator |

## Verification
The bench checks that the pin floats in the gap between reset release and the first strobe. A design that enabled the driver from its reset defaults would show a wrong level on the pad. It sends a second strobe with different bits and then checks the old behaviour. A design that re-captured would change polarity in mid-operation. Open-drain is tried in both polarities, where a driver that drives a high level would fight the pull-up. The bench also tries power-good with gating both on and off, and it samples the mode indicator just before and just after the clock edge to catch a path that is not registered.

// File: rtl/wake_pin_driver.sv
module wake_pin_driver (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_valid,
  input  logic cfg_pol,
  input  logic cfg_gate,
  input  logic cfg_odrain,
  input  logic wake_req,
  input  logic pwr_good,
  input  logic magic_mode,
  output logic pin_o,
  output logic pin_oe,
  output logic mode_led
);

  logic loaded, pol_q, gate_q, od_q;
  logic level, allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      pol_q  <= 1'b0;
      gate_q <= 1'b0;
      od_q   <= 1'b0;
    end else if (cfg_valid && !loaded) begin
      loaded <= 1'b1;
      pol_q  <= cfg_pol;
      gate_q <= cfg_gate;
      od_q   <= cfg_odrain;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_led <= 1'b0;
    else        mode_led <= magic_mode;
  end

  assign level  = wake_req ? pol_q : ~pol_q;
  assign allow  = loaded & ~(gate_q & ~pwr_good);
  assign pin_oe = allow & (od_q ? ~level : 1'b1);
  assign pin_o  = allow & ~od_q & level;

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> ($stable(pol_q) && $stable(gate_q) && $stable(od_q))); // R3
  AST_GATED_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && gate_q && !pwr_good) |-> !pin_oe); // R6
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && od_q) |-> !(pin_oe && pin_o)); // R5
  AST_LED_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mode_led == $past(magic_mode))); // R7
  AST_UNLOADED_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !pin_oe); // R2

  always_comb begin
    if (rst_n && !pin_oe) AST_FLOAT_ZERO: assert (!pin_o); // R8
  end

endmodule

// File: tb/sim_wake_pin_driver.sv
module sim_wake_pin_driver;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 0, cfg_pol = 0, cfg_gate = 0, cfg_odrain = 0;
  logic wake_req = 0, pwr_good = 0, magic_mode = 0;
  logic pin_o, pin_oe, mode_led;
  int vectors = 0, miscompares = 0;

  always #5 clk = ~clk;

  wake_pin_driver u0 (.clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_pol(cfg_pol),
    .cfg_gate(cfg_gate), .cfg_odrain(cfg_odrain), .wake_req(wake_req), .pwr_good(pwr_good),
    .magic_mode(magic_mode), .pin_o(pin_o), .pin_oe(pin_oe), .mode_led(mode_led));

  task automatic check(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic want_oe(logic p, logic g, logic od, logic w, logic pg);
    logic lvl = w ? p : ~p;
    if (g && !pg) return 1'b0;
    return od ? ~lvl : 1'b1;
  endfunction

  function automatic logic want_o(logic p, logic g, logic od, logic w, logic pg);
    if (g && !pg) return 1'b0;
    return od ? 1'b0 : (w ? p : ~p);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cfg_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic load(logic p, logic g, logic od);
    do_reset();
    cfg_pol = p; cfg_gate = g; cfg_odrain = od; cfg_valid = 1;
    @(negedge clk); cfg_valid = 0;
  endtask

  task automatic sweep(string tag, logic p, logic g, logic od);
    for (int w = 0; w < 2; w++)
      for (int pg = 0; pg < 2; pg++) begin
        @(negedge clk); wake_req = w[0]; pwr_good = pg[0]; #1;
        check({tag, " oe"}, pin_oe, want_oe(p, g, od, w[0], pg[0]));
        check({tag, " o"}, pin_o, want_o(p, g, od, w[0], pg[0]));
        if (!pin_oe) check("R8 float zero", pin_o, 1'b0);
      end
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 0; wake_req = 1; pwr_good = 1; magic_mode = 1; #1;
    check("R1 oe", pin_oe, 1'b0);
    check("R1 o", pin_o, 1'b0);
    @(posedge clk); #1;
    check("R1 led", mode_led, 1'b0);
    magic_mode = 0;
  endtask

  task automatic t_unloaded();
    do_reset();
    cfg_pol = 1; cfg_odrain = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); wake_req = i[0]; pwr_good = i[1]; #1;
      check("R2 unloaded oe", pin_oe, 1'b0);
    end
  endtask

  task automatic t_pushpull();
    load(1, 0, 0); sweep("R4 pp pol1", 1, 0, 0);
    load(0, 0, 0); sweep("R4 pp pol0", 0, 0, 0);
  endtask

  task automatic t_opendrain();
    load(1, 0, 1); sweep("R5 od pol1", 1, 0, 1);
    load(0, 0, 1); sweep("R5 od pol0", 0, 0, 1);
  endtask

  task automatic t_gate();
    load(1, 1, 0); sweep("R6 gate pp", 1, 1, 0);
    load(0, 1, 1); sweep("R6 gate od", 0, 1, 1);
    load(0, 0, 0); sweep("R6 nogate", 0, 0, 0);
  endtask

  task automatic t_relock();
    load(1, 0, 0);
    @(negedge clk); cfg_pol = 0; cfg_gate = 1; cfg_odrain = 1; cfg_valid = 1;
    @(negedge clk); cfg_valid = 0;
    sweep("R3 locked", 1, 0, 0);
    load(0, 1, 1); sweep("R3 reload", 0, 1, 1);
  endtask

  task automatic t_mode();
    for (int i = 0; i < 3; i++) begin
      logic v = (i != 1);
      @(negedge clk); magic_mode = v; #1;
      check("R7 before edge", mode_led, ~v);
      @(posedge clk); #1;
      check("R7 after edge", mode_led, v);
    end
  endtask

  initial begin
    #500000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_unloaded();
    t_pushpull();
    t_opendrain();
    t_gate();
    t_relock();
    magic_mode = 0; do_reset();
    t_mode();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule